// File: doc/BRIEF.md
# Mixed-Decay Off-Time Current Chopper

This block sequences the four switches of one H-bridge winding for fixed off-time current regulation. When enabled, it turns on one diagonal pair of switches so that current builds in the direction given by the phase bit. A blanking window follows each on-phase start, and the current-trip comparator is ignored inside it. Once the window has closed, a trip starts a one-shot off-time. The off-time begins with a fast-decay portion, in which the bridge is driven in reverse. A slow-decay portion follows, in which both low-side switches conduct. An all-off dead gap sits at every decay transition. The off-time is followed by a new on-phase.

While the bridge decays, the switches that short the body diodes are turned on for synchronous rectification. They are turned off when the zero-current detector asserts, so the load current never reverses. A fault or undervoltage input forces all four switches off at once and parks the sequencer. All durations are counted in clock cycles from parameters. One parameter selects between two off-time lengths.

The states are COAST (all off), BLANK (driving, trip ignored), ON (driving, trip watched), DT_ON, FAST, DT_MID, SLOW and DT_END. The transitions are:
- COAST to BLANK when enabled.
- BLANK to ON when the blank count expires.
- ON to DT_ON on a trip.
- DT_ON to FAST, FAST to DT_MID, DT_MID to SLOW, SLOW to DT_END, and DT_END to BLANK, each when its count expires.
- Any state to COAST on a fault or when the enable is low.

Top module: `decay_chopper`

## Requirements
- R1: In BLANK and ON, the phase bit latched at on-phase start selects the pair. Phase 1 turns on hi_a and lo_b. Phase 0 turns on hi_b and lo_a. The other two switches stay off.
- R2: For BLANK_CYC cycles after each on-phase start, the trip input is ignored. With the trip held high, the drive pattern lasts BLANK_CYC+1 cycles.
- R3: The off-time runs from the first FAST cycle to the last SLOW cycle and lasts OFF cycles. OFF is OFF_ALT_CYC when USE_ALT is 1 and OFF_STD_CYC otherwise.
- R4: FAST lasts floor(OFF*301/1000) cycles. It drives the reverse pair: hi_b and lo_a for phase 1, hi_a and lo_b for phase 0.
- R5: SLOW lasts OFF - FAST - DEAD_CYC cycles, with lo_a and lo_b on.
- R6: All four switches are off for DEAD_CYC cycles in each of three places: before FAST, between FAST and SLOW, and after SLOW.
- R7: A zero-current detect during an off-time turns off the rectifying switches until the next on-phase. In FAST all four switches are then off. In SLOW only the sink low-side stays on: lo_b for phase 1, lo_a for phase 0.
- R8: Reset leaves all switches off. A fault turns all switches off in the same cycle and holds them off while it stays high. After it clears, the sequencer restarts with a full blanking window.
- R9: With the enable low, all switches stay off and the trip input has no effect. Raising the enable starts an on-phase with blanking.
- R10: A phase-bit change takes effect only at the next on-phase start.
- R11: No leg ever has its high and low switch on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Nonzero current request |
| dir_i | input | 1 | Phase (current direction) bit |
| trip_i | input | 1 | Current-trip comparator |
| zero_i | input | 1 | Zero-current detect |
| fault_i | input | 1 | Fault or undervoltage lockout |
| hi_a_o | output | 1 | Leg A high-side enable |
| lo_a_o | output | 1 | Leg A low-side enable |
| hi_b_o | output | 1 | Leg B high-side enable |
| lo_b_o | output | 1 | Leg B low-side enable |

## Verification
The assertions check four properties on every cycle:
- Neither leg is ever shorted.
- Every dead gap is all off.
- FAST with a latched zero detect is all off.
- A fault always parks the sequencer, the blanking window is never left early, and the latched phase changes only at on-phase start.

Only the bench scenarios can show the cycle lengths of each drive and decay pattern, the choice of off-time by USE_ALT, the pattern seen under each phase, the recovery after a fault or a dropped enable, and the return of rectification on the following off-time.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_COAST,
        ST_BLANK,
        ST_ON,
        ST_DT_ON,
        ST_FAST,
        ST_DT_MID,
        ST_SLOW,
        ST_DT_END
    } chop_state_e;

    typedef struct packed {
        logic hi_a;
        logic lo_a;
        logic hi_b;
        logic lo_b;
    } gate_t;

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
(
    input  chop_state_e state_i,
    input  logic        dir_i,
    input  logic        sr_cut_i,
    input  logic        fault_i,
    output gate_t       gate_o
);
    always_comb begin
        gate_o = '0;
        if (!fault_i) begin
            unique case (state_i)
                ST_BLANK, ST_ON: begin
                    if (dir_i) begin
                        gate_o.hi_a = 1'b1;
                        gate_o.lo_b = 1'b1;
                    end else begin
                        gate_o.hi_b = 1'b1;
                        gate_o.lo_a = 1'b1;
                    end
                end
                ST_FAST: begin
                    if (!sr_cut_i) begin
                        if (dir_i) begin
                            gate_o.hi_b = 1'b1;
                            gate_o.lo_a = 1'b1;
                        end else begin
                            gate_o.hi_a = 1'b1;
                            gate_o.lo_b = 1'b1;
                        end
                    end
                end
                ST_SLOW: begin
                    gate_o.lo_b = dir_i  | !sr_cut_i;
                    gate_o.lo_a = !dir_i | !sr_cut_i;
                end
                default: gate_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/decay_chopper.sv
module decay_chopper
    import chop_pkg::*;
#(
    parameter int OFF_STD_CYC = 1500,
    parameter int OFF_ALT_CYC = 405,
    parameter int USE_ALT     = 0,
    parameter int BLANK_CYC   = 50,
    parameter int DEAD_CYC    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dir_i,
    input  logic trip_i,
    input  logic zero_i,
    input  logic fault_i,
    output logic hi_a_o,
    output logic lo_a_o,
    output logic hi_b_o,
    output logic lo_b_o
);
    localparam int OFF_CYC  = (USE_ALT != 0) ? OFF_ALT_CYC : OFF_STD_CYC;
    localparam int FAST_CYC = (OFF_CYC * 301) / 1000;
    localparam int SLOW_CYC = OFF_CYC - FAST_CYC - DEAD_CYC;
    localparam int MAX_CYC  = OFF_CYC + BLANK_CYC + DEAD_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    chop_state_e      state_q, state_d;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             dir_q;
    logic             zc_q;
    logic             sr_cut;
    logic             enter_blank;
    gate_t            gate;

    function automatic int state_len(chop_state_e s);
        case (s)
            ST_BLANK:                       return BLANK_CYC;
            ST_DT_ON, ST_DT_MID, ST_DT_END: return DEAD_CYC;
            ST_FAST:                        return FAST_CYC;
            ST_SLOW:                        return SLOW_CYC;
            default:                        return 1;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (fault_i || !en_i) begin
            state_d = ST_COAST;
        end else begin
            unique case (state_q)
                ST_COAST:  state_d = ST_BLANK;
                ST_BLANK:  if (tmr_done) state_d = ST_ON;
                ST_ON:     if (trip_i)   state_d = ST_DT_ON;
                ST_DT_ON:  if (tmr_done) state_d = ST_FAST;
                ST_FAST:   if (tmr_done) state_d = ST_DT_MID;
                ST_DT_MID: if (tmr_done) state_d = ST_SLOW;
                ST_SLOW:   if (tmr_done) state_d = ST_DT_END;
                ST_DT_END: if (tmr_done) state_d = ST_BLANK;
                default:   state_d = ST_COAST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COAST;
        else        state_q <= state_d;
    end

    assign tmr_load    = (state_d != state_q);
    assign tmr_val     = CNT_W'(state_len(state_d) - 1);
    assign enter_blank = (state_d == ST_BLANK) && (state_q != ST_BLANK);

    chop_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    // phase latch and zero-current latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            zc_q  <= 1'b0;
        end else begin
            if (enter_blank) dir_q <= dir_i;
            if (enter_blank || state_d == ST_COAST) begin
                zc_q <= 1'b0;
            end else if (zero_i && (state_q == ST_FAST || state_q == ST_DT_MID
                                    || state_q == ST_SLOW)) begin
                zc_q <= 1'b1;
            end
        end
    end

    assign sr_cut = zc_q | zero_i;

    // output decode
    chop_gate_map i_gate_map (
        .state_i  (state_q),
        .dir_i    (dir_q),
        .sr_cut_i (sr_cut),
        .fault_i  (fault_i),
        .gate_o   (gate)
    );

    assign hi_a_o = gate.hi_a;
    assign lo_a_o = gate.lo_a;
    assign hi_b_o = gate.hi_b;
    assign lo_b_o = gate.lo_b;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_a_o && lo_a_o)); // R11
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_b_o && lo_b_o)); // R11
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !tmr_done) |=> (state_q == ST_BLANK || state_q == ST_COAST)); // R2
    AST_DEAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DT_ON || state_q == ST_DT_MID || state_q == ST_DT_END)
            |-> !(hi_a_o || lo_a_o || hi_b_o || lo_b_o)); // R6
    AST_ZC_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST && zc_q) |-> !(hi_a_o || lo_a_o || hi_b_o || lo_b_o)); // R7
    AST_FAULT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (state_q == ST_COAST)); // R8
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BLANK) |-> $stable(dir_q)); // R10

endmodule

// File: tb/test_decay_chopper.sv
module test_decay_chopper;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_STD = 200;
    localparam int OFF_ALT = 100;
    localparam int BLANK   = 5;
    localparam int DEAD    = 3;
    localparam int OFF     = OFF_ALT;              // USE_ALT = 1
    localparam int FAST    = (OFF * 301) / 1000;
    localparam int SLOW    = OFF - FAST - DEAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir = 1'b0, trip = 1'b0, zero = 1'b0, fault = 1'b0;
    logic hi_a, lo_a, hi_b, lo_b;
    int checks = 0, failures = 0, leg_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    decay_chopper #(
        .OFF_STD_CYC(OFF_STD), .OFF_ALT_CYC(OFF_ALT), .USE_ALT(1),
        .BLANK_CYC(BLANK), .DEAD_CYC(DEAD)
    ) i_decay_chopper (
        .clk(clk), .rst_n(rst_n), .en_i(en), .dir_i(dir), .trip_i(trip),
        .zero_i(zero), .fault_i(fault),
        .hi_a_o(hi_a), .lo_a_o(lo_a), .hi_b_o(hi_b), .lo_b_o(lo_b)
    );

    function automatic logic [3:0] pat();
        return {hi_a, lo_a, hi_b, lo_b};
    endfunction

    always @(negedge clk) if ((hi_a && lo_a) || (hi_b && lo_b)) leg_bad++;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_pat(input logic [3:0] exp, input string tag);
        check(pat() == exp, tag, pat(), exp);
    endtask

    task automatic measure(input logic [3:0] p, input int exp_len, input string tag,
                           output int len);
        int n = 0;
        while (pat() == p && n < 1000) begin
            n++;
            tick(1);
        end
        len = n;
        check(n == exp_len, tag, n, exp_len);
    endtask

    initial begin
        int l_fast, l_slow, l_dt, l;
        tick(3);
        check_pat(4'b0000, "R8 reset all off");
        rst_n = 1'b1;
        tick(2);
        check_pat(4'b0000, "R9 enable low coast");
        trip = 1'b1;
        tick(3);
        check_pat(4'b0000, "R9 trip ignored in coast");

        // phase 1 full cycle, trip held
        dir = 1'b1; en = 1'b1;
        tick(1);
        check_pat(4'b1001, "R1 phase1 pair");
        measure(4'b1001, BLANK + 1, "R2 blank with trip high", l);
        measure(4'b0000, DEAD, "R6 dead before fast", l);
        measure(4'b0110, FAST, "R4 fast phase1", l_fast);
        measure(4'b0000, DEAD, "R6 dead mid", l_dt);
        measure(4'b0101, SLOW, "R5 slow both lows", l_slow);
        check(l_fast + l_dt + l_slow == OFF, "R3 off-time total", l_fast + l_dt + l_slow, OFF);
        measure(4'b0000, DEAD, "R6 dead after slow", l);
        trip = 1'b0;
        tick(40);
        check_pat(4'b1001, "R1 on held without trip");

        // phase change mid on-phase
        dir = 1'b0;
        tick(5);
        check_pat(4'b1001, "R10 phase not applied mid on");
        trip = 1'b1;
        tick(1);
        measure(4'b0000, DEAD, "R6 dead before fast", l);
        measure(4'b0110, FAST, "R10 fast uses old phase", l);
        measure(4'b0000, DEAD, "R6 dead mid", l);
        measure(4'b0101, SLOW, "R5 slow", l);
        measure(4'b0000, DEAD, "R6 dead end", l);
        check_pat(4'b0110, "R10 new phase at on start");
        measure(4'b0110, BLANK + 1, "R1 phase0 drive", l);
        measure(4'b0000, DEAD, "R6", l);
        measure(4'b1001, FAST, "R4 fast phase0", l);
        measure(4'b0000, DEAD, "R6", l);
        measure(4'b0101, SLOW, "R5", l);
        measure(4'b0000, DEAD, "R6", l);

        // zero-current detect in fast, phase 0
        measure(4'b0110, BLANK + 1, "R2", l);
        measure(4'b0000, DEAD, "R6", l);
        check_pat(4'b1001, "R4 fast start");
        zero = 1'b1;
        tick(1);
        check_pat(4'b0000, "R7 rectification cut");
        zero = 1'b0;
        measure(4'b0000, FAST - 1 + DEAD, "R7 cut held through fast", l);
        measure(4'b0100, SLOW, "R7 slow sink only", l);
        measure(4'b0000, DEAD, "R6", l);
        measure(4'b0110, BLANK + 1, "R2", l);
        measure(4'b0000, DEAD, "R6", l);
        check_pat(4'b1001, "R7 rectification restored");

        // fault during on-phase
        trip = 1'b0;
        measure(4'b1001, FAST, "R4", l);
        measure(4'b0000, DEAD, "R6", l);
        measure(4'b0101, SLOW, "R5", l);
        measure(4'b0000, DEAD, "R6", l);
        tick(10);
        check_pat(4'b0110, "R1 on phase0");
        fault = 1'b1;
        #1;
        check_pat(4'b0000, "R8 fault immediate off");
        tick(4);
        check_pat(4'b0000, "R8 fault held off");
        fault = 1'b0;
        #1;
        check_pat(4'b0000, "R8 coast after fault");
        tick(1);
        trip = 1'b1;
        measure(4'b0110, BLANK + 1, "R8 restart with blank", l);

        // enable dropped in fast
        measure(4'b0000, DEAD, "R6", l);
        en = 1'b0;
        tick(1);
        check_pat(4'b0000, "R9 enable low off");
        tick(5);
        check_pat(4'b0000, "R9 coast held");
        en = 1'b1;
        tick(1);
        measure(4'b0110, BLANK + 1, "R9 restart with blank", l);

        check(leg_bad == 0, "R11 leg exclusive", leg_bad, 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule